// File: doc/BRIEF.md
# Interrupt Pin Service and End-of-Interrupt Engine

This block watches a bank of interrupt request pins and turns each serviced request into a message write. A message is an address/data pair formed from the pin's configuration. Each pin has its own configuration, supplied continuously on a parallel bus:

- a mask bit;
- a trigger mode (edge or level);
- an 8-bit vector;
- a 3-bit delivery mode;
- a destination-mode bit;
- a 16-bit destination.

For every pin the block keeps a request flag. Level-mode pins also keep a remote-pending flag, which stops the same request from being reissued until the receiver signals end-of-interrupt for that vector.

Request inputs are synchronous and sampled on every clock. Edge detection compares each sample with the one taken on the previous clock. Pin 0 is not serviced in its own right: its request is folded onto pin 2, so pin 2's configuration governs it.

Each cycle the block picks the lowest-numbered pin that is eligible and loads its message into a single output register. That register presents the message on a valid/ready stream. While `msg_valid` is high and `msg_ready` is low, the message and its valid flag hold unchanged and no new pin is picked. A new message can load in the same cycle the previous one is accepted, so a continuously ready sink sees one message per clock. Because the configuration is read combinationally every cycle, any configuration change (unmasking, a mode switch) takes effect in the next scan without an explicit trigger.

Top module: `irq_pin_router`

## Requirements
- R1: After reset `msg_valid` is low, and no message appears until some pin request arrives.
- R2: A request on pin 0 is serviced exactly as a request on pin 2: it uses pin 2's configuration, mask and mode.
- R3: In level mode the request flag follows the sampled pin level. A high pin yields a message. A pin that is low when its remote-pending flag clears yields none.
- R4: In edge mode a rising edge on an unmasked pin yields exactly one message. A rising edge while the pin is masked is discarded, and unmasking later does not recover it.
- R5: Once a level pin's message has been loaded, its remote-pending flag is set and no further message is issued for that pin while the flag stays set. An end-of-interrupt carrying a different vector leaves the flag set.
- R6: An end-of-interrupt whose vector equals a level pin's vector clears that pin's remote-pending flag. If the pin is unmasked and still requesting, it is serviced again.
- R7: `msg_addr` = 0xFEE00000 OR (destination << 4) OR (destination mode << 2). The destination occupies bits 19:4 and the destination mode bit 2.
- R8: `msg_data` holds the vector in bits 7:0, the delivery mode in bits 10:8 and the trigger mode in bit 15 (1 = level, 0 = edge). All other bits are zero.
- R9: When several pins are eligible at once, they are issued in ascending pin order.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady.
- R11: A pin in edge mode never keeps a remote-pending flag. Switching a level pin to edge mode clears its flag, so a later level request is serviced without an end-of-interrupt.
- R12: Configuration changes trigger service. A masked level pin with its request high produces a message once it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_req | input | NPINS | Interrupt request pins, sampled each clock |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_vector | input | NPINS*8 | Per-pin vector, pin i at bits 8i+7:8i |
| cfg_dlv | input | NPINS*3 | Per-pin delivery mode, pin i at bits 3i+2:3i |
| cfg_dmode | input | NPINS | Per-pin destination mode bit |
| cfg_dest | input | NPINS*16 | Per-pin destination, pin i at bits 16i+15:16i |
| eoi_valid | input | 1 | End-of-interrupt strobe, one cycle per event |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Message present on msg_addr/msg_data |
| msg_ready | input | 1 | Sink accepts the message at this clock edge |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bound checker watches the stream and the remote-pending flags on every cycle. It checks that a stalled message holds, that every presented address and data word keeps its fixed and zero bits, that remote-pending never survives in an edge-mode pin, and that a pin only gains remote-pending in a cycle that loads a message. Behaviours that depend on history can only be shown by the bench's scenarios: pin 0 folding onto pin 2, a masked edge being lost for good, suppression until a matching end-of-interrupt, the reissue afterwards, and ascending-order issue under back-pressure. The bench shows them with directed scenarios and with a cycle-by-cycle reference model.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  localparam int VEC_W  = 8;
  localparam int DLV_W  = 3;
  localparam int DEST_W = 16;

  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;
  localparam int DEST_LSB  = 4;
  localparam int DMODE_BIT = 2;
  localparam int DLV_LSB   = 8;
  localparam int TRIG_BIT  = 15;

  function automatic logic [31:0] form_addr(input logic [DEST_W-1:0] dest,
                                            input logic dm);
    return MSG_BASE | (32'(dest) << DEST_LSB) | (32'(dm) << DMODE_BIT);
  endfunction

  function automatic logic [31:0] form_data(input logic [VEC_W-1:0] vec,
                                            input logic [DLV_W-1:0] dlv,
                                            input logic lvl);
    return 32'(vec) | (32'(dlv) << DLV_LSB) | (32'(lvl) << TRIG_BIT);
  endfunction
endpackage

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
  import irq_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             mask,
  input  logic             level,
  input  logic [VEC_W-1:0] vector,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             issue,
  output logic             eligible,
  output logic             pend,
  output logic             remote
);
  logic req_q;
  logic rise;
  logic eoi_hit;

  assign rise    = req & ~req_q;
  assign eoi_hit = eoi_valid && (vector == eoi_vector);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend   <= 1'b0;
      remote <= 1'b0;
    end else begin
      req_q <= req;
      // request flag: level follows the pin; edge latches unmasked rises
      if (level)               pend <= req;
      else if (rise && !mask)  pend <= 1'b1;
      else if (issue)          pend <= 1'b0;
      // remote-pending only lives in level mode
      if (!level)              remote <= 1'b0;
      else if (issue)          remote <= 1'b1;
      else if (eoi_hit)        remote <= 1'b0;
    end
  end

  assign eligible = pend & ~mask & (~level | ~remote);
endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
  parameter int N = 24,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_msg_stage.sv
module irq_msg_stage (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        fill,
  input  logic [31:0] addr_in,
  input  logic [31:0] data_in,
  output logic        valid,
  output logic [31:0] addr,
  output logic [31:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= fill;
      if (fill) begin
        addr <= addr_in;
        data <= data_in;
      end
    end
  end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_pin_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        pin_req,
  input  logic [NPINS-1:0]        cfg_mask,
  input  logic [NPINS-1:0]        cfg_level,
  input  logic [NPINS*VEC_W-1:0]  cfg_vector,
  input  logic [NPINS*DLV_W-1:0]  cfg_dlv,
  input  logic [NPINS-1:0]        cfg_dmode,
  input  logic [NPINS*DEST_W-1:0] cfg_dest,
  input  logic                    eoi_valid,
  input  logic [VEC_W-1:0]        eoi_vector,
  output logic                    msg_valid,
  input  logic                    msg_ready,
  output logic [31:0]             msg_addr,
  output logic [31:0]             msg_data
);
  localparam int IDX_W = $clog2(NPINS);

  logic [NPINS-1:0] eff_req;
  logic [NPINS-1:0] elig;
  logic [NPINS-1:0] pend;
  logic [NPINS-1:0] remote;
  logic [NPINS-1:0] issue;
  logic             found;
  logic [IDX_W-1:0] sel;
  logic             load;
  logic [31:0]      addr_in;
  logic [31:0]      data_in;

  // pin 0 folds onto pin 2; slot 0 never sees a request
  for (genvar g = 0; g < NPINS; g++) begin : g_slot
    if (g == 0) begin : g_fold
      assign eff_req[g] = 1'b0;
    end else if (g == 2) begin : g_merge
      assign eff_req[g] = pin_req[2] | pin_req[0];
    end else begin : g_plain
      assign eff_req[g] = pin_req[g];
    end

    irq_pin_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (eff_req[g]),
      .mask       (cfg_mask[g]),
      .level      (cfg_level[g]),
      .vector     (cfg_vector[g*VEC_W +: VEC_W]),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .issue      (issue[g]),
      .eligible   (elig[g]),
      .pend       (pend[g]),
      .remote     (remote[g])
    );
  end

  irq_first_pick #(.N(NPINS)) u_pick (
    .cand  (elig),
    .found (found),
    .idx   (sel)
  );

  assign load  = ~msg_valid | msg_ready;
  assign issue = (load && found) ? (NPINS'(1) << sel) : '0;

  assign addr_in = form_addr(cfg_dest[sel*DEST_W +: DEST_W], cfg_dmode[sel]);
  assign data_in = form_data(cfg_vector[sel*VEC_W +: VEC_W],
                             cfg_dlv[sel*DLV_W +: DLV_W], cfg_level[sel]);

  irq_msg_stage u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .fill    (found),
    .addr_in (addr_in),
    .data_in (data_in),
    .valid   (msg_valid),
    .addr    (msg_addr),
    .data    (msg_data)
  );
endmodule

// File: rtl/irq_pin_router_chk.sv
module irq_pin_router_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] cfg_level,
  input logic [NPINS-1:0] remote,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data
);
  logic was_rst;
  always_ff @(posedge clk) begin
    was_rst <= !rst_n;
    if (was_rst) begin
      assert_reset_idle_R1: assert (!msg_valid)
        else $error("R1: message valid right after reset");
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_addr_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[31:20] == 12'hFEE && msg_addr[3] == 1'b0 && msg_addr[1:0] == 2'b00));

  assert_data_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:16] == 16'h0 && msg_data[14:11] == 4'h0));

  assert_edge_no_remote_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((remote & ~$past(cfg_level)) == '0));

  assert_remote_on_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((remote & ~$past(remote)) == '0) || msg_valid));
endmodule

bind irq_pin_router irq_pin_router_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_level (cfg_level),
  .remote    (remote),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data)
);

// File: tb/irq_pin_router_test.sv
module irq_pin_router_test;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]    pin_req = '0;
  logic [N-1:0]    mask_b = '0;
  logic [N-1:0]    lvl_b = '0;
  logic [N-1:0]    dm_b = '0;
  logic [7:0]      vec_b  [N];
  logic [2:0]      dlv_b  [N];
  logic [15:0]     dest_b [N];
  logic [N*8-1:0]  cfg_vector;
  logic [N*3-1:0]  cfg_dlv;
  logic [N*16-1:0] cfg_dest;
  logic            eoi_valid = 1'b0;
  logic [7:0]      eoi_vector = '0;
  logic            msg_ready = 1'b1;
  logic            msg_valid;
  logic [31:0]     msg_addr, msg_data;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_vector[i*8 +: 8]   = vec_b[i];
      cfg_dlv[i*3 +: 3]      = dlv_b[i];
      cfg_dest[i*16 +: 16]   = dest_b[i];
    end
  end

  irq_pin_router #(.NPINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .pin_req(pin_req), .cfg_mask(mask_b),
    .cfg_level(lvl_b), .cfg_vector(cfg_vector), .cfg_dlv(cfg_dlv),
    .cfg_dmode(dm_b), .cfg_dest(cfg_dest), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int checks = 0;
  int fails = 0;

  function automatic logic [31:0] exp_addr(int p);
    return 32'hFEE0_0000 | ({16'h0, dest_b[p]} << 4) | (32'(dm_b[p]) << 2);
  endfunction
  function automatic logic [31:0] exp_data(int p);
    return {16'h0, lvl_b[p], 4'h0, dlv_b[p], vec_b[p]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_pend [N];
  bit          m_rem  [N];
  bit          m_prev [N];
  bit          m_valid;
  logic [31:0] m_addr, m_data;

  function automatic bit eff(int p);
    if (p == 0) return 1'b0;
    if (p == 2) return pin_req[2] | pin_req[0];
    return pin_req[p];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_rem[i] = 0; m_prev[i] = 0; end
      m_valid = 0; m_addr = '0; m_data = '0;
    end else begin
      int pick;
      bit was_rem [N];
      pick = -1;
      for (int i = 0; i < N; i++) was_rem[i] = m_rem[i];
      if (!m_valid || msg_ready) begin
        for (int i = N - 1; i >= 0; i--)
          if (m_pend[i] && !mask_b[i] && (!lvl_b[i] || !m_rem[i])) pick = i;
        m_valid = (pick >= 0);
        if (pick >= 0) begin m_addr = exp_addr(pick); m_data = exp_data(pick); end
      end
      for (int i = 0; i < N; i++) begin
        bit e;
        e = eff(i);
        if (!lvl_b[i]) m_rem[i] = 0;
        else if (i == pick) m_rem[i] = 1;
        else if (eoi_valid && eoi_vector == vec_b[i] && was_rem[i]) m_rem[i] = 0;
        if (lvl_b[i]) m_pend[i] = e;
        else if (e && !m_prev[i] && !mask_b[i]) m_pend[i] = 1;
        else if (i == pick) m_pend[i] = 0;
        m_prev[i] = e;
      end
    end
  end

  // accepted-message log and per-cycle comparison
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(msg_valid == m_valid, "R9 R10 model valid", 32'(msg_valid), 32'(m_valid));
      if (m_valid && msg_valid) begin
        chk(msg_addr == m_addr, "R7 model addr", msg_addr, m_addr);
        chk(msg_data == m_data, "R8 model data", msg_data, m_data);
      end
      if (msg_valid && msg_ready) begin q_addr.push_back(msg_addr); q_data.push_back(msg_data); end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic clr();
    q_addr.delete(); q_data.delete();
  endtask
  task automatic pulse(input int p);
    @(negedge clk); pin_req[p] = 1'b1;
    @(negedge clk); pin_req[p] = 1'b0;
  endtask
  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      vec_b[i] = 8'h20 + 8'(i); dlv_b[i] = 3'(i % 8);
      dest_b[i] = 16'(16'h0100 * i + i); dm_b[i] = i[0];
    end
    cyc(3);
    @(negedge clk); rst_n = 1'b1;
    cyc(4);
    chk(!msg_valid, "R1 idle after reset", 32'(msg_valid), 0);
    chk(q_addr.size() == 0, "R1 no message", q_addr.size(), 0);

    // R4 + R7 + R8: single edge
    clr(); pulse(5); cyc(6);
    chk(q_addr.size() == 1, "R4 edge count", q_addr.size(), 1);
    if (q_addr.size() == 1) begin
      chk(q_addr[0] == exp_addr(5), "R7 address", q_addr[0], exp_addr(5));
      chk(q_data[0] == exp_data(5), "R8 data", q_data[0], exp_data(5));
      chk(q_data[0] == 32'h0000_0525, "R8 literal", q_data[0], 32'h0000_0525);
    end

    // R4: masked edge dropped
    clr(); mask_b[6] = 1'b1; pulse(6); cyc(3);
    @(negedge clk); mask_b[6] = 1'b0; cyc(6);
    chk(q_addr.size() == 0, "R4 masked edge", q_addr.size(), 0);

    // R2: pin 0 uses pin 2
    clr(); pulse(0); cyc(6);
    chk(q_addr.size() == 1, "R2 fold count", q_addr.size(), 1);
    if (q_addr.size() == 1) chk(q_data[0] == exp_data(2), "R2 fold data", q_data[0], exp_data(2));

    // R3/R5/R6: level pin 9
    @(negedge clk); lvl_b[9] = 1'b1;
    clr(); @(negedge clk); pin_req[9] = 1'b1; cyc(10);
    chk(q_addr.size() == 1, "R5 suppressed", q_addr.size(), 1);
    if (q_addr.size() == 1) chk(q_data[0][15] == 1'b1, "R8 level trigger bit", 32'(q_data[0][15]), 1);
    clr(); eoi(8'h77); cyc(6);
    chk(q_addr.size() == 0, "R5 wrong vector", q_addr.size(), 0);
    clr(); eoi(8'h29); cyc(6);
    chk(q_addr.size() == 1, "R6 reissue", q_addr.size(), 1);
    clr(); @(negedge clk); pin_req[9] = 1'b0; cyc(3); eoi(8'h29); cyc(6);
    chk(q_addr.size() == 0, "R3 low level", q_addr.size(), 0);

    // R9/R10: ordering under back-pressure
    clr(); @(negedge clk); msg_ready = 1'b0; pin_req[12] = 1'b1; pin_req[7] = 1'b1;
    @(negedge clk); pin_req[12] = 1'b0; pin_req[7] = 1'b0;
    cyc(4);
    begin
      logic [31:0] snap;
      snap = msg_addr;
      cyc(3);
      chk(msg_valid && msg_addr == snap, "R10 stall hold", msg_addr, snap);
    end
    @(negedge clk); msg_ready = 1'b1; cyc(6);
    chk(q_addr.size() == 2, "R9 order count", q_addr.size(), 2);
    if (q_addr.size() == 2) begin
      chk(q_data[0][7:0] == 8'h27, "R9 first", q_data[0], 32'h27);
      chk(q_data[1][7:0] == 8'h2C, "R9 second", q_data[1], 32'h2C);
    end

    // R11: mode switch clears remote-pending
    @(negedge clk); lvl_b[14] = 1'b1;
    clr(); @(negedge clk); pin_req[14] = 1'b1; cyc(6);
    @(negedge clk); pin_req[14] = 1'b0; cyc(3);
    @(negedge clk); lvl_b[14] = 1'b0; cyc(2);
    @(negedge clk); lvl_b[14] = 1'b1; cyc(2);
    @(negedge clk); pin_req[14] = 1'b1; cyc(6);
    chk(q_addr.size() == 2, "R11 no eoi needed", q_addr.size(), 2);
    @(negedge clk); pin_req[14] = 1'b0;

    // R12: unmask triggers service
    @(negedge clk); lvl_b[16] = 1'b1; mask_b[16] = 1'b1;
    clr(); @(negedge clk); pin_req[16] = 1'b1; cyc(6);
    chk(q_addr.size() == 0, "R12 masked level", q_addr.size(), 0);
    @(negedge clk); mask_b[16] = 1'b0; cyc(6);
    chk(q_addr.size() == 1, "R12 unmask service", q_addr.size(), 1);
    @(negedge clk); pin_req[16] = 1'b0; cyc(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule